// File: doc/BRIEF.md
# Host command parameter sequencer

This block sits between a host processor and the command engine of a disc controller. The host writes a command byte, then feeds the parameter bytes one at a time through a parameter port. The sequencer works out from the command byte how many parameters to expect. It stores each one into an internal register file, starting at a fixed top slot and moving down. When the last one arrives it hands the command to the engine with a one-cycle start strobe that carries the base command code.

Two command families are executed inside the block. A register read takes an index parameter and returns the indexed register through the result port. A streaming register write takes a destination index followed by three values. Each value lands in the register file the moment it arrives, so the effect is kept even if the command is abandoned. Every parameter write also gives a one-cycle event pulse toward the internal dispatcher. A busy flag covers the time from a command write until its completion.

Top module: `cmd_param_seq`

## Requirements
- R1: After reset, busy, start, prm_evt and result are all 0 and every register file entry holds 0.
- R2: For a general command, the parameter count is command bits [1:0] and the start code is the command with bits [1:0] cleared. Start is high for exactly one cycle: the cycle after the clock edge that captured the last parameter, or after the command write when the count is 0.
- R3: Parameters of a command are stored at register index 7, then 6, then 5, in order of arrival.
- R4: A register read command (code 0x3C to 0x3F) reads the register whose index is parameter one modulo 32, and loads that value into result. This happens one cycle after its last parameter, with no start pulse. A count above 1 makes the block wait for the extra parameters, which do not change the value read.
- R5: A streaming write command (code 0x7C to 0x7F) always takes four parameters, whatever bits [1:0] hold. The first is a destination index modulo 32. Each of the next three is written to the destination on arrival, and the destination then steps up by one, wrapping from 31 to 0. Values already written stay in place if another command replaces it. It gives no start pulse and leaves result unchanged.
- R6: Every parameter port write, in any state, makes prm_evt high for the following cycle only.
- R7: busy rises the cycle after a command write and falls in the same cycle as the start pulse or the result update. A command write while busy drops the pending command and starts collection again for the new one.
- R8: A parameter write while not busy changes no register file entry, does not set busy and gives no start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command byte write strobe |
| prm_we | input | 1 | Parameter byte write strobe |
| wdata | input | 8 | Host write data |
| busy | output | 1 | A command is collecting or executing |
| prm_evt | output | 1 | Parameter-written event pulse |
| start | output | 1 | One-cycle start strobe for the command engine |
| start_code | output | 8 | Base command code carried with start |
| result | output | 8 | Result register |

## Verification
The assertions take for granted that cmd_we and prm_we are single-cycle strobes sampled cleanly at the rising edge, and that a command write takes precedence when both come in the same cycle. The stimulus drives every strobe for exactly one cycle from the falling edge and never raises both at once. It also leaves at least one idle cycle after a command completes before checking, so the one-cycle start and event pulses are seen in isolation.

// File: rtl/cps_pkg.sv
package cps_pkg;

  typedef enum logic [1:0] {
    K_GEN = 2'd0,
    K_RD  = 2'd1,
    K_STR = 2'd2
  } kind_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_COLL = 2'd1,
    S_STRM = 2'd2,
    S_EXEC = 2'd3
  } st_t;

endpackage

// File: rtl/cps_decode.sv
module cps_decode
  import cps_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 2,
  parameter int NEED_W      = 3,
  parameter int STREAM_VALS = 3,
  parameter logic [DATA_W-1:0] RD_CODE = 8'h3C,
  parameter logic [DATA_W-1:0] WR_CODE = 8'h7C
) (
  input  logic [DATA_W-1:0] cmd,
  output logic [DATA_W-1:0] base,
  output logic [NEED_W-1:0] need,
  output kind_t             kind
);

  always_comb begin
    base = {cmd[DATA_W-1:CNT_W], {CNT_W{1'b0}}};
    if (base == RD_CODE) begin
      kind = K_RD;
    end else if (base == WR_CODE) begin
      kind = K_STR;
    end else begin
      kind = K_GEN;
    end
    if (kind == K_STR) begin
      need = NEED_W'(STREAM_VALS + 1);
    end else begin
      need = NEED_W'(cmd[CNT_W-1:0]);
    end
  end

endmodule

// File: rtl/cps_regfile.sv
module cps_regfile #(
  parameter int DATA_W  = 8,
  parameter int REG_N   = 32,
  parameter int TOP_IDX = 7,
  parameter int IW      = $clog2(REG_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IW-1:0]     widx,
  input  logic [DATA_W-1:0] wd,
  input  logic [DATA_W-1:0] rd_key,
  output logic [DATA_W-1:0] top_q,
  output logic [DATA_W-1:0] rd_q
);

  logic [DATA_W-1:0] mem [REG_N];
  logic [IW-1:0]     ridx;

  for (genvar g = 0; g < REG_N; g++) begin : g_reg
    logic en;
    assign en = we && (widx == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[g] <= '0;
      end else if (en) begin
        mem[g] <= wd;
      end
    end
  end

  always_comb begin
    ridx  = IW'(rd_key % REG_N);
    rd_q  = mem[ridx];
    top_q = mem[TOP_IDX];
  end

endmodule

// File: rtl/cps_ctrl.sv
module cps_ctrl
  import cps_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int REG_N       = 32,
  parameter int TOP_IDX     = 7,
  parameter int NEED_W      = 3,
  parameter int STREAM_VALS = 3,
  parameter int IW          = $clog2(REG_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic              prm_we,
  input  logic [DATA_W-1:0] wdata,
  input  kind_t             d_kind,
  input  logic [DATA_W-1:0] d_base,
  input  logic [NEED_W-1:0] d_need,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rf_we,
  output logic [IW-1:0]     rf_idx,
  output logic [DATA_W-1:0] rf_wd,
  output logic              busy,
  output logic              prm_evt,
  output logic              start,
  output logic [DATA_W-1:0] start_code,
  output logic [DATA_W-1:0] result
);

  st_t               st_q,   st_d;
  kind_t             kind_q, kind_d;
  logic [DATA_W-1:0] code_q, code_d;
  logic [NEED_W-1:0] need_q, need_d;
  logic [IW-1:0]     slot_q, slot_d;
  logic [IW-1:0]     ptr_q,  ptr_d;
  logic              start_d;
  logic              res_ld;

  always_comb begin
    st_d    = st_q;
    kind_d  = kind_q;
    code_d  = code_q;
    need_d  = need_q;
    slot_d  = slot_q;
    ptr_d   = ptr_q;
    rf_we   = 1'b0;
    rf_idx  = slot_q;
    rf_wd   = wdata;
    start_d = 1'b0;
    res_ld  = 1'b0;
    if (cmd_we) begin
      kind_d = d_kind;
      code_d = d_base;
      need_d = d_need;
      slot_d = IW'(TOP_IDX);
      st_d   = (d_need == '0) ? S_EXEC : S_COLL;
    end else begin
      unique case (st_q)
        S_COLL: begin
          if (prm_we) begin
            rf_we  = 1'b1;
            rf_idx = slot_q;
            if (kind_q == K_STR) begin
              ptr_d  = IW'(wdata % REG_N);
              need_d = NEED_W'(STREAM_VALS);
              st_d   = S_STRM;
            end else begin
              slot_d = slot_q - 1'b1;
              need_d = need_q - 1'b1;
              if (need_q == NEED_W'(1)) begin
                st_d = S_EXEC;
              end
            end
          end
        end
        S_STRM: begin
          if (prm_we) begin
            rf_we  = 1'b1;
            rf_idx = ptr_q;
            ptr_d  = ptr_q + 1'b1;
            need_d = need_q - 1'b1;
            if (need_q == NEED_W'(1)) begin
              st_d = S_EXEC;
            end
          end
        end
        S_EXEC: begin
          st_d    = S_IDLE;
          start_d = (kind_q == K_GEN);
          res_ld  = (kind_q == K_RD);
        end
        default: begin
          st_d = S_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      kind_q     <= K_GEN;
      code_q     <= '0;
      need_q     <= '0;
      slot_q     <= '0;
      ptr_q      <= '0;
      start      <= 1'b0;
      start_code <= '0;
      prm_evt    <= 1'b0;
      result     <= '0;
    end else begin
      st_q    <= st_d;
      kind_q  <= kind_d;
      code_q  <= code_d;
      need_q  <= need_d;
      slot_q  <= slot_d;
      ptr_q   <= ptr_d;
      start   <= start_d;
      prm_evt <= prm_we;
      if (start_d) begin
        start_code <= code_q;
      end
      if (res_ld) begin
        result <= rd_data;
      end
    end
  end

  assign busy = (st_q != S_IDLE);

endmodule

// File: rtl/cmd_param_seq.sv
module cmd_param_seq
  import cps_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int REG_N       = 32,
  parameter int TOP_IDX     = 7,
  parameter int CNT_W       = 2,
  parameter int STREAM_VALS = 3,
  parameter logic [DATA_W-1:0] RD_CODE = 8'h3C,
  parameter logic [DATA_W-1:0] WR_CODE = 8'h7C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic              prm_we,
  input  logic [DATA_W-1:0] wdata,
  output logic              busy,
  output logic              prm_evt,
  output logic              start,
  output logic [DATA_W-1:0] start_code,
  output logic [DATA_W-1:0] result
);

  localparam int IW     = $clog2(REG_N);
  localparam int NEED_W = CNT_W + 1;

  kind_t             d_kind;
  logic [DATA_W-1:0] d_base;
  logic [NEED_W-1:0] d_need;
  logic              rf_we;
  logic [IW-1:0]     rf_idx;
  logic [DATA_W-1:0] rf_wd;
  logic [DATA_W-1:0] top_q;
  logic [DATA_W-1:0] rd_q;

  cps_decode #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .NEED_W(NEED_W),
    .STREAM_VALS(STREAM_VALS), .RD_CODE(RD_CODE), .WR_CODE(WR_CODE)
  ) i_decode (
    .cmd  (wdata),
    .base (d_base),
    .need (d_need),
    .kind (d_kind)
  );

  cps_regfile #(
    .DATA_W(DATA_W), .REG_N(REG_N), .TOP_IDX(TOP_IDX), .IW(IW)
  ) i_regfile (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (rf_we),
    .widx   (rf_idx),
    .wd     (rf_wd),
    .rd_key (top_q),
    .top_q  (top_q),
    .rd_q   (rd_q)
  );

  cps_ctrl #(
    .DATA_W(DATA_W), .REG_N(REG_N), .TOP_IDX(TOP_IDX), .NEED_W(NEED_W),
    .STREAM_VALS(STREAM_VALS), .IW(IW)
  ) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_we     (cmd_we),
    .prm_we     (prm_we),
    .wdata      (wdata),
    .d_kind     (d_kind),
    .d_base     (d_base),
    .d_need     (d_need),
    .rd_data    (rd_q),
    .rf_we      (rf_we),
    .rf_idx     (rf_idx),
    .rf_wd      (rf_wd),
    .busy       (busy),
    .prm_evt    (prm_evt),
    .start      (start),
    .start_code (start_code),
    .result     (result)
  );

endmodule

// File: rtl/cps_chk.sv
module cps_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_we,
  input logic              prm_we,
  input logic              busy,
  input logic              prm_evt,
  input logic              start,
  input logic [DATA_W-1:0] start_code,
  input logic [DATA_W-1:0] result
);

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);                                            // R2
  AST_START_CODE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (start_code[1:0] == 2'b00));                        // R2
  AST_START_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);                                             // R7
  AST_CMD_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we |=> busy);                                             // R7
  AST_EVT_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    prm_we |=> prm_evt);                                          // R6
  AST_EVT_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !prm_we |=> !prm_evt);                                        // R6
  AST_IDLE_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cmd_we) |=> !busy);                                // R8
  AST_RESULT_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cmd_we) |=> $stable(result));                      // R4

endmodule

bind cmd_param_seq cps_chk #(.DATA_W(DATA_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_we     (cmd_we),
  .prm_we     (prm_we),
  .busy       (busy),
  .prm_evt    (prm_evt),
  .start      (start),
  .start_code (start_code),
  .result     (result)
);

// File: tb/test_cmd_param_seq.sv
`timescale 1ns/1ps
module test_cmd_param_seq;

  logic       clk;
  logic       rst_n;
  logic       cmd_we;
  logic       prm_we;
  logic [7:0] wdata;
  logic       busy;
  logic       prm_evt;
  logic       start;
  logic [7:0] start_code;
  logic [7:0] result;

  int n_run;
  int n_fail;
  bit done;

  cmd_param_seq i_cmd_param_seq (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .prm_we(prm_we),
    .wdata(wdata), .busy(busy), .prm_evt(prm_evt), .start(start),
    .start_code(start_code), .result(result)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Bytes: [10] req, [9] cmd, [8:5] params, [4] count sent,
  // [3] start expected, [2] start code, [1] result checked, [0] result
  localparam int NV = 9;
  localparam logic [10:0][7:0] TV [NV] = '{
    {8'd2, 8'h40, 8'h00, 8'h00, 8'h00, 8'h00, 8'd0, 8'd1, 8'h40, 8'd0, 8'h00},
    {8'd2, 8'h41, 8'hAA, 8'h00, 8'h00, 8'h00, 8'd1, 8'd1, 8'h40, 8'd0, 8'h00},
    {8'd2, 8'h83, 8'h11, 8'h22, 8'h33, 8'h00, 8'd3, 8'd1, 8'h80, 8'd0, 8'h00},
    {8'd3, 8'h3D, 8'h06, 8'h00, 8'h00, 8'h00, 8'd1, 8'd0, 8'h00, 8'd1, 8'h22},
    {8'd4, 8'h3E, 8'h05, 8'h99, 8'h00, 8'h00, 8'd2, 8'd0, 8'h00, 8'd1, 8'h33},
    {8'd5, 8'h7C, 8'h10, 8'hA1, 8'hA2, 8'hA3, 8'd4, 8'd0, 8'h00, 8'd1, 8'h33},
    {8'd5, 8'h3D, 8'h11, 8'h00, 8'h00, 8'h00, 8'd1, 8'd0, 8'h00, 8'd1, 8'hA2},
    {8'd4, 8'h3D, 8'h07, 8'h00, 8'h00, 8'h00, 8'd1, 8'd0, 8'h00, 8'd1, 8'h07},
    {8'd2, 8'hC2, 8'h05, 8'h06, 8'h00, 8'h00, 8'd2, 8'd1, 8'hC0, 8'd0, 8'h00}
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr_cmd(input logic [7:0] v);
    @(negedge clk);
    cmd_we = 1'b1;
    wdata  = v;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic wr_prm(input logic [7:0] v);
    @(negedge clk);
    prm_we = 1'b1;
    wdata  = v;
    @(negedge clk);
    prm_we = 1'b0;
    chk("R6 prm_evt after write", {7'd0, prm_evt}, 8'd1);
  endtask

  // one read command with index p, result checked one cycle later
  task automatic rd_reg(input logic [7:0] p, input logic [7:0] exp, input string tag);
    wr_cmd(8'h3D);
    wr_prm(p);
    @(negedge clk);
    chk(tag, result, exp);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: got hang expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    n_run  = 0;
    n_fail = 0;
    done   = 1'b0;
    cmd_we = 1'b0;
    prm_we = 1'b0;
    wdata  = 8'h00;
    rst_n  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", {7'd0, busy}, 8'd0);
    chk("R1 start", {7'd0, start}, 8'd0);
    chk("R1 prm_evt", {7'd0, prm_evt}, 8'd0);
    chk("R1 result", result, 8'h00);
    rd_reg(8'h03, 8'h00, "R1 register reset value");
    rd_reg(8'h1F, 8'h00, "R1 register reset value");

    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = $sformatf("R%0d vector %0d", TV[v][10], v);
      wr_cmd(TV[v][9]);
      for (int k = 0; k < int'(TV[v][4]); k++) begin
        chk({tag, " busy while collecting (R7)"}, {7'd0, busy}, 8'd1);
        wr_prm(TV[v][8-k]);
      end
      chk({tag, " busy before completion (R7)"}, {7'd0, busy}, 8'd1);
      @(negedge clk);
      chk({tag, " start"}, {7'd0, start}, TV[v][3]);
      chk({tag, " busy cleared (R7)"}, {7'd0, busy}, 8'd0);
      if (TV[v][3] != 8'd0) chk({tag, " start code"}, start_code, TV[v][2]);
      if (TV[v][1] != 8'd0) chk({tag, " result"}, result, TV[v][0]);
      @(negedge clk);
      chk({tag, " start drops (R2)"}, {7'd0, start}, 8'd0);
    end

    // R3 third parameter went to index 5
    rd_reg(8'h05, 8'h33, "R3 index 5 holds third parameter");

    // R8 parameter write while idle
    wr_prm(8'h5A);
    chk("R8 not busy after idle write", {7'd0, busy}, 8'd0);
    @(negedge clk);
    chk("R8 no start after idle write", {7'd0, start}, 8'd0);
    rd_reg(8'h05, 8'h33, "R8 index 5 unchanged");
    rd_reg(8'h06, 8'h06, "R8 index 6 unchanged");

    // R7 replacement while busy
    wr_cmd(8'h83);
    wr_prm(8'h01);
    wr_cmd(8'h40);
    chk("R7 no start from dropped command", {7'd0, start}, 8'd0);
    @(negedge clk);
    chk("R7 replacement starts", {7'd0, start}, 8'd1);
    chk("R7 replacement code", start_code, 8'h40);

    // R5 partial stream keeps its write
    wr_cmd(8'h7C);
    wr_prm(8'h14);
    wr_prm(8'hB4);
    chk("R5 still busy mid stream", {7'd0, busy}, 8'd1);
    rd_reg(8'h14, 8'hB4, "R5 partial stream value kept");

    // R5 stream low bits ignored and index wrap
    wr_cmd(8'h7F);
    wr_prm(8'h1F);
    wr_prm(8'hC1);
    wr_prm(8'hC2);
    chk("R5 low bits ignored, still busy", {7'd0, busy}, 8'd1);
    wr_prm(8'hC3);
    @(negedge clk);
    chk("R5 stream done, no start", {7'd0, start}, 8'd0);
    chk("R5 stream done, not busy", {7'd0, busy}, 8'd0);
    rd_reg(8'h1F, 8'hC1, "R5 value at index 31");
    rd_reg(8'h00, 8'hC2, "R5 wrapped to index 0");
    rd_reg(8'h21, 8'hC3, "R5 index modulo 32 reads index 1");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule